// File: doc/BRIEF.md
# Adjustable Tick Clock with Drift Compensation

This block holds a 48-bit local time value that moves forward in discrete steps rather than every cycle. A programmable tick generator counts system-clock cycles. On each tick the time value grows by a 32-bit step amount plus a 16-bit signed correction term that trims the frequency error of the local oscillator. The upper 32 bits count seconds and the lower 16 bits hold the fraction, so a step amount of 0x10000 adds one second.

A small real-time-clock divider runs beside the time register. It takes a 32,768 Hz enable and counts whole seconds with a 15-bit prescaler. A start pulse copies that seconds count into the time register, clears the fraction and begins accumulation. Software reaches the step amount, the correction term, the tick period and the time value through one write port. A direct time write wins over a tick that falls in the same cycle.

Top module: `adj_tick_clock`

## Requirements
- R1: After reset, time_o is 0, running_o is 0, rtc_sec_o is 0 and tick_o is low. The step amount and the correction term are 0, and the tick period is DEF_PERIOD.
- R2: While running, tick_o is high for one cycle every P cycles, where P is the period register (address 3, bits 23:0); P of 0 or 1 gives a tick every cycle. If P is lowered below the current count, the next tick comes in the following cycle.
- R3: On a tick, time_o becomes time_o + step amount (address 1, bits 31:0, zero-extended) + correction term (address 2, bits 15:0, two's complement, sign-extended), modulo 2^48.
- R4: In a cycle with no tick, no time write and no start, time_o keeps its value.
- R5: Each rtc_en pulse advances a 15-bit prescaler. rtc_sec_o rises by one on every 32,768th pulse.
- R6: A start pulse loads time_o with {rtc_sec_o, 16'h0000}, sets running_o and restarts the tick count. The first tick follows P cycles after the start edge. Start wins over a time write and over a tick.
- R7: A write to address 0 loads time_o with wr_data and takes the place of a tick in the same cycle.
- R8: Writes to the step amount or the correction term apply from the next tick. A tick in the same cycle as such a write uses the old value.
- R9: Before the first start, tick_o stays low and time_o changes only through writes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rtc_en | input | 1 | One-cycle enable at the 32,768 Hz rate |
| start | input | 1 | Load seconds into time and begin accumulation |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 time, 1 step amount, 2 correction, 3 period |
| wr_data | input | 48 | Write data, right-aligned per register |
| time_o | output | 48 | Current time: 32-bit seconds, 16-bit fraction |
| tick_o | output | 1 | One-cycle pulse in each update cycle |
| rtc_sec_o | output | 32 | Seconds counted by the divider |
| running_o | output | 1 | High once a start has been seen |

## Verification
The bench aims at the cycles where two sources meet. A tick coinciding with a time write would show a design with the wrong priority adding the step on top of the written value. A tick coinciding with a step or correction write would show a design that reads the new values too early. A negative correction that is zero-extended instead of sign-extended adds almost 2^16 rather than subtracting. A tick at all-ones time exposes a design that saturates instead of wrapping. Sweeping the period from 0 to 6, including cuts below the running count, catches off-by-one reloads. Watching the prescaler at the 32,767th and 32,768th enable catches a one-second boundary that lands one pulse early or late.

// File: rtl/tclk_pkg.sv
package tclk_pkg;
  typedef enum logic [1:0] {
    SEL_TIME   = 2'd0,
    SEL_STEP   = 2'd1,
    SEL_TRIM   = 2'd2,
    SEL_PERIOD = 2'd3
  } tclk_sel_e;
endpackage

// File: rtl/tclk_regs.sv
module tclk_regs
  import tclk_pkg::*;
#(
  parameter int TIME_W     = 48,
  parameter int STEP_W     = 32,
  parameter int TRIM_W     = 16,
  parameter int PER_W      = 24,
  parameter int DEF_PERIOD = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [TIME_W-1:0] wr_data,
  output logic [STEP_W-1:0] step_q,
  output logic [TRIM_W-1:0] trim_q,
  output logic [PER_W-1:0]  period_q,
  output logic              time_wr
);
  logic step_wr, trim_wr, per_wr;
  logic unused_hi;

  assign time_wr   = wr_en && (tclk_sel_e'(wr_addr) == SEL_TIME);
  assign step_wr   = wr_en && (tclk_sel_e'(wr_addr) == SEL_STEP);
  assign trim_wr   = wr_en && (tclk_sel_e'(wr_addr) == SEL_TRIM);
  assign per_wr    = wr_en && (tclk_sel_e'(wr_addr) == SEL_PERIOD);
  assign unused_hi = ^wr_data[TIME_W-1:STEP_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= '0;
      trim_q   <= '0;
      period_q <= PER_W'(DEF_PERIOD);
    end else begin
      if (step_wr) step_q   <= wr_data[STEP_W-1:0];
      if (trim_wr) trim_q   <= wr_data[TRIM_W-1:0];
      if (per_wr)  period_q <= wr_data[PER_W-1:0];
    end
  end

  // R8: written values appear only after the edge
  a_r8_step_load: assert property (@(posedge clk) disable iff (!rst_n)
    step_wr |=> step_q == $past(wr_data[STEP_W-1:0]));
  a_r8_trim_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trim_wr |=> $stable(trim_q));
endmodule

// File: rtl/tclk_tick_gen.sv
module tclk_tick_gen #(
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  localparam logic [PER_W-1:0] ONE = PER_W'(1);
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] lim;

  assign lim  = (period == '0) ? ONE : period;
  assign tick = run && (cnt >= lim - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (run)     cnt <= tick ? '0 : cnt + ONE;
  end

  a_r9_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && period > ONE) |=> (!tick || period <= ONE));
  a_r6_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && period > ONE) |=> !tick);
endmodule

// File: rtl/tclk_rtc_div.sv
module tclk_rtc_div #(
  parameter int DIV_W = 15,
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rtc_en,
  output logic [SEC_W-1:0] sec
);
  logic [DIV_W-1:0] div;
  logic             wrap;

  assign wrap = rtc_en && (&div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div <= '0;
      sec <= '0;
    end else if (rtc_en) begin
      div <= div + DIV_W'(1);
      if (wrap) sec <= sec + SEC_W'(1);
    end
  end

  a_r5_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> sec == $past(sec) + SEC_W'(1));
  a_r5_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(sec));
endmodule

// File: rtl/tclk_accum.sv
module tclk_accum #(
  parameter int TIME_W = 48,
  parameter int STEP_W = 32,
  parameter int TRIM_W = 16,
  parameter int SEC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              time_wr,
  input  logic [TIME_W-1:0] wr_val,
  input  logic              tick,
  input  logic [STEP_W-1:0] step,
  input  logic [TRIM_W-1:0] trim,
  input  logic [SEC_W-1:0]  sec,
  output logic [TIME_W-1:0] time_q,
  output logic              running
);
  localparam int FRAC_W = TIME_W - SEC_W;

  function automatic logic [TIME_W-1:0] step_amount(
    input logic [STEP_W-1:0] s, input logic [TRIM_W-1:0] t);
    return {{(TIME_W-STEP_W){1'b0}}, s} + {{(TIME_W-TRIM_W){t[TRIM_W-1]}}, t};
  endfunction

  function automatic logic [TIME_W-1:0] boot_value(input logic [SEC_W-1:0] s);
    return {s, {FRAC_W{1'b0}}};
  endfunction

  logic do_tick;
  assign do_tick = tick && !start && !time_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q  <= '0;
      running <= 1'b0;
    end else begin
      if (start) begin
        time_q  <= boot_value(sec);
        running <= 1'b1;
      end else if (time_wr) begin
        time_q <= wr_val;
      end else if (do_tick) begin
        time_q <= time_q + step_amount(step, trim);
      end
    end
  end

  a_r3_tick_add: assert property (@(posedge clk) disable iff (!rst_n)
    do_tick |=> time_q == $past(time_q) + step_amount($past(step), $past(trim)));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start && !time_wr) |=> $stable(time_q));
  a_r6_boot: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (time_q[FRAC_W-1:0] == '0) && (time_q[TIME_W-1:FRAC_W] == $past(sec)) && running);
  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (time_wr && !start) |=> time_q == $past(wr_val));
endmodule

// File: rtl/adj_tick_clock.sv
module adj_tick_clock
  import tclk_pkg::*;
#(
  parameter int TIME_W     = 48,
  parameter int STEP_W     = 32,
  parameter int TRIM_W     = 16,
  parameter int PER_W      = 24,
  parameter int DIV_W      = 15,
  parameter int DEF_PERIOD = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_en,
  input  logic              start,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [TIME_W-1:0] wr_data,
  output logic [TIME_W-1:0] time_o,
  output logic              tick_o,
  output logic [31:0]       rtc_sec_o,
  output logic              running_o
);
  localparam int SEC_W = 32;

  logic [STEP_W-1:0] step_q;
  logic [TRIM_W-1:0] trim_q;
  logic [PER_W-1:0]  period_q;
  logic              time_wr;
  logic              tick_w;
  logic [SEC_W-1:0]  sec_w;

  tclk_regs #(.TIME_W(TIME_W), .STEP_W(STEP_W), .TRIM_W(TRIM_W),
              .PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .step_q(step_q), .trim_q(trim_q),
    .period_q(period_q), .time_wr(time_wr));

  tclk_tick_gen #(.PER_W(PER_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(running_o), .restart(start),
    .period(period_q), .tick(tick_w));

  tclk_rtc_div #(.DIV_W(DIV_W), .SEC_W(SEC_W)) u_rtc (
    .clk(clk), .rst_n(rst_n), .rtc_en(rtc_en), .sec(sec_w));

  tclk_accum #(.TIME_W(TIME_W), .STEP_W(STEP_W), .TRIM_W(TRIM_W),
               .SEC_W(SEC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .time_wr(time_wr),
    .wr_val(wr_data), .tick(tick_w), .step(step_q), .trim(trim_q),
    .sec(sec_w), .time_q(time_o), .running(running_o));

  assign tick_o    = tick_w;
  assign rtc_sec_o = sec_w;

  // R1: quiet outputs right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (time_o == '0) && !running_o && !tick_o);
endmodule

// File: tb/adj_tick_clock_tb.sv
module adj_tick_clock_tb;
  localparam int DEF_P = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rtc_en = 1'b0;
  logic        start = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [47:0] wr_data = '0;
  logic [47:0] time_o;
  logic        tick_o;
  logic [31:0] rtc_sec_o;
  logic        running_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adj_tick_clock u_dut (
    .clk(clk), .rst_n(rst_n), .rtc_en(rtc_en), .start(start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .time_o(time_o), .tick_o(tick_o), .rtc_sec_o(rtc_sec_o),
    .running_o(running_o));

  // Reference state built from the requirements
  logic [47:0] m_time;
  logic [31:0] m_step;
  logic [15:0] m_trim;
  logic [23:0] m_per;
  logic        m_run;
  int unsigned m_ph;
  int unsigned en_cnt;

  function automatic int unsigned eff_period(input logic [23:0] p);
    return (p < 24'd2) ? 1 : int'(p);
  endfunction

  function automatic logic [47:0] advance(input logic [47:0] t,
      input logic [31:0] s, input logic [15:0] d);
    logic [47:0] r;
    r = t + {16'h0, s};
    if (d[15]) r = r - {32'h0, (17'h10000 - {1'b0, d})};
    else       r = r + {32'h0, d};
    return r;
  endfunction

  logic exp_tick;
  assign exp_tick = m_run && (m_ph + 1 >= eff_period(m_per));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_time <= '0; m_step <= '0; m_trim <= '0; m_per <= 24'(DEF_P);
      m_run <= 0; m_ph <= 0; en_cnt <= 0;
    end else begin
      if (rtc_en) en_cnt <= en_cnt + 1;
      if (start) begin
        m_time <= {en_cnt >> 15, 16'h0};
        m_run <= 1; m_ph <= 0;
      end else begin
        if (wr_en && wr_addr == 2'd0) m_time <= wr_data;
        else if (exp_tick) m_time <= advance(m_time, m_step, m_trim);
        if (m_run) m_ph <= exp_tick ? 0 : m_ph + 1;
      end
      if (wr_en && wr_addr == 2'd1) m_step <= wr_data[31:0];
      if (wr_en && wr_addr == 2'd2) m_trim <= wr_data[15:0];
      if (wr_en && wr_addr == 2'd3) m_per  <= wr_data[23:0];
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One cycle: wait for the falling edge, compare, release one-shot inputs
  task automatic step(input string tag);
    @(negedge clk);
    chk(tag, {16'h0, time_o}, {16'h0, m_time});
    chk("R2 tick", {63'h0, tick_o}, {63'h0, exp_tick});
    wr_en = 0; start = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [47:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic to_tick();
    int guard = 0;
    while (!exp_tick && guard < 100) begin step("R3"); guard++; end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [47:0] t0, ld;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 time", {16'h0, time_o}, 64'h0);
    chk("R1 running", {63'h0, running_o}, 64'h0);
    chk("R1 sec", {32'h0, rtc_sec_o}, 64'h0);
    chk("R1 tick", {63'h0, tick_o}, 64'h0);
    rtc_en = 1;
    // R9: configure and idle before start, no ticks
    wr(2'd3, 48'd4); step("R9");
    wr(2'd1, 48'h10000); step("R9");
    wr(2'd2, 48'd3); step("R9");
    run(20, "R9");
    // R5: one-second boundary of the prescaler
    while (en_cnt < 32767) @(negedge clk);
    chk("R5 before wrap", {32'h0, rtc_sec_o}, 64'd0);
    @(negedge clk);
    chk("R5 at wrap", {32'h0, rtc_sec_o}, 64'd1);
    while (en_cnt < 65540) @(negedge clk);
    chk("R5 two seconds", {32'h0, rtc_sec_o}, 64'd2);
    // R6: start loads seconds with cleared fraction
    ld = {en_cnt >> 15, 16'h0};
    start = 1; step("R6");
    chk("R6 load", {16'h0, time_o}, {16'h0, ld});
    chk("R6 running", {63'h0, running_o}, 64'h1);
    run(3, "R6");
    chk("R6 first tick", {63'h0, tick_o}, 64'h1);
    run(40, "R3");
    run(12, "R4");
    // R8: new step/trim written in a tick cycle do not touch that tick
    to_tick();
    t0 = time_o;
    wr(2'd1, 48'h7); step("R8");
    chk("R8 old step", {16'h0, time_o}, {16'h0, t0 + 48'h10003});
    to_tick();
    wr(2'd2, 48'hFFFB); step("R8");
    run(12, "R8");
    // R7: time write in a tick cycle
    to_tick();
    wr(2'd0, 48'hFFFF_FFFF_FFF0); step("R7");
    chk("R7 write wins", {16'h0, time_o}, 64'hFFFF_FFFF_FFF0);
    // R3: wrap modulo 2^48 with negative trim (7 - 5 = 2)
    to_tick();
    wr(2'd0, 48'hFFFF_FFFF_FFFF); step("R7");
    to_tick(); step("R3");
    chk("R3 wrap", {16'h0, time_o}, 64'h1);
    // R2: period sweep, including cuts below the running count
    for (int p = 0; p <= 6; p++) begin
      wr(2'd3, 48'(p)); step("R2");
      run(3 * eff_period(24'(p)) + 2, "R2");
    end
    // R6: restart while running
    wr(2'd3, 48'd5); step("R2");
    run(2, "R3");
    ld = {en_cnt >> 15, 16'h0};
    start = 1; step("R6");
    chk("R6 restart", {16'h0, time_o}, {16'h0, ld});
    run(12, "R6");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule